// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station

This block is the scheduling core of a dynamically scheduled pipeline. It has three parts. A register alias table keeps, for every architectural register, a tag, a value and a valid bit. A small pool of station entries holds instructions that are waiting for their operands. A single result bus, driven from outside, carries one producer tag and its value per cycle.

An issuing instruction is accepted only when a station entry is free. When it is accepted, each source operand is resolved through the alias table, either to a value or to the tag of the instruction that will produce it. The destination register is then renamed to the tag of the new entry. Waiting entries watch the result bus and capture operands whose tags match. An entry whose two operands are present is offered to the functional unit, and the lowest-numbered ready entry goes first. An entry stays allocated until its own tag appears on the result bus. Its tag then becomes free for reuse.

Top module: `rs_sched`

## Requirements
- R1: When every station entry is occupied, `iss_stall` is high, and an instruction presented on the issue port is dropped: no entry is allocated and the alias table is left unchanged.
- R2: An accepted instruction takes each source operand as a value when the alias table shows that register valid, and otherwise records the producer tag held in the table.
- R3: If an issuing source names a pending register whose producer tag is on the result bus in the same cycle, the entry captures the bus value at insertion and treats that operand as ready.
- R4: A waiting entry whose source tag equals the tag of a result-bus broadcast captures the broadcast value and marks that source ready.
- R5: `disp_valid` is high only for an entry that holds both operands and has not yet been sent. When several entries qualify, the lowest-numbered one is presented. An entry is sent once, in a cycle with `disp_ready` high.
- R6: On a broadcast, an alias-table row is written and marked valid only when it is pending and its stored tag equals the broadcast tag. A broadcast from an older, overwritten producer leaves the row pending.
- R7: An accepted instruction is placed in the lowest-numbered free entry. Its tag is that entry's index, and the destination row of the alias table is set to this tag and marked pending at the next clock.
- R8: A station entry is released when its tag is broadcast on the result bus, and a later issue can allocate it again.
- R9: After reset every entry is free, nothing is presented for dispatch, and every alias-table row is valid with value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Opcode of the issuing instruction |
| iss_dst | input | log2(NREG) | Destination register |
| iss_src0 | input | log2(NREG) | First source register |
| iss_src1 | input | log2(NREG) | Second source register |
| iss_stall | output | 1 | No free station entry; issue is not accepted |
| cdb_valid | input | 1 | Result-bus broadcast valid |
| cdb_tag | input | log2(NRS) | Tag of the broadcast result |
| cdb_value | input | DW | Broadcast result value |
| disp_ready | input | 1 | Functional unit accepts the presented entry |
| disp_valid | output | 1 | An entry is ready for dispatch |
| disp_tag | output | log2(NRS) | Tag (entry index) of the presented entry |
| disp_op | output | OPW | Opcode of the presented entry |
| disp_a | output | DW | First operand of the presented entry |
| disp_b | output | DW | Second operand of the presented entry |
| rd_idx | input | log2(NREG) | Alias-table lookup index |
| rd_valid | output | 1 | Valid bit of the looked-up row |
| rd_tag | output | log2(NRS) | Tag of the looked-up row |
| rd_value | output | DW | Value of the looked-up row |

## Verification
The assertions assume that a broadcast tag always names an entry that is allocated and has already been sent for dispatch, and that each such tag is broadcast only once. Under that assumption the entry release and the one-row-at-a-time loss of alias-table validity hold. The bench plays the functional unit itself. It broadcasts only tags it has just taken from the dispatch port, each one once. It never broadcasts a tag whose entry is free, so the stimulus stays within what the checks take for granted.

// File: rtl/rs_sched.sv
module rs_sched #(
  parameter int NREG = 8,
  parameter int NRS  = 4,
  parameter int DW   = 16,
  parameter int OPW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [OPW-1:0]          iss_op,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [$clog2(NREG)-1:0] iss_src0,
  input  logic [$clog2(NREG)-1:0] iss_src1,
  output logic                    iss_stall,
  input  logic                    cdb_valid,
  input  logic [$clog2(NRS)-1:0]  cdb_tag,
  input  logic [DW-1:0]           cdb_value,
  input  logic                    disp_ready,
  output logic                    disp_valid,
  output logic [$clog2(NRS)-1:0]  disp_tag,
  output logic [OPW-1:0]          disp_op,
  output logic [DW-1:0]           disp_a,
  output logic [DW-1:0]           disp_b,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic                    rd_valid,
  output logic [$clog2(NRS)-1:0]  rd_tag,
  output logic [DW-1:0]           rd_value
);
  localparam int RW = $clog2(NREG);
  localparam int TW = $clog2(NRS);

  logic [NRS-1:0]  busy, sent, rdy0, rdy1;
  logic [TW-1:0]   tg0 [NRS];
  logic [TW-1:0]   tg1 [NRS];
  logic [DW-1:0]   vl0 [NRS];
  logic [DW-1:0]   vl1 [NRS];
  logic [OPW-1:0]  opq [NRS];

  logic [NREG-1:0] rat_vld;
  logic [TW-1:0]   rat_tag [NREG];
  logic [DW-1:0]   rat_val [NREG];

  logic [TW-1:0]   free_idx, pick_idx;
  logic            has_free, has_pick;
  logic [NRS-1:0]  ready;

  assign ready = busy & ~sent & rdy0 & rdy1;

  always_comb begin
    free_idx = '0; has_free = 1'b0;
    pick_idx = '0; has_pick = 1'b0;
    for (int i = NRS-1; i >= 0; i--) begin
      if (!busy[i]) begin free_idx = TW'(i); has_free = 1'b1; end
      if (ready[i]) begin pick_idx = TW'(i); has_pick = 1'b1; end
    end
  end

  logic ins, fire;
  assign ins       = iss_valid && has_free;
  assign fire      = has_pick && disp_ready;
  assign iss_stall = !has_free;

  logic          s0_hit, s1_hit;
  logic [DW-1:0] s0_val, s1_val;
  assign s0_hit = rat_vld[iss_src0] || (cdb_valid && cdb_tag == rat_tag[iss_src0]);
  assign s1_hit = rat_vld[iss_src1] || (cdb_valid && cdb_tag == rat_tag[iss_src1]);
  assign s0_val = rat_vld[iss_src0] ? rat_val[iss_src0] : cdb_value;
  assign s1_val = rat_vld[iss_src1] ? rat_val[iss_src1] : cdb_value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; sent <= '0; rdy0 <= '0; rdy1 <= '0;
      for (int i = 0; i < NRS; i++) begin
        tg0[i] <= '0; tg1[i] <= '0; vl0[i] <= '0; vl1[i] <= '0; opq[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (cdb_valid && cdb_tag == TW'(i)) begin
          busy[i] <= 1'b0;
          sent[i] <= 1'b0;
        end
        if (busy[i] && !rdy0[i] && cdb_valid && tg0[i] == cdb_tag) begin
          rdy0[i] <= 1'b1; vl0[i] <= cdb_value;
        end
        if (busy[i] && !rdy1[i] && cdb_valid && tg1[i] == cdb_tag) begin
          rdy1[i] <= 1'b1; vl1[i] <= cdb_value;
        end
        if (fire && pick_idx == TW'(i)) sent[i] <= 1'b1;
        if (ins && free_idx == TW'(i)) begin
          busy[i] <= 1'b1;
          sent[i] <= 1'b0;
          opq[i]  <= iss_op;
          rdy0[i] <= s0_hit; tg0[i] <= rat_tag[iss_src0]; vl0[i] <= s0_val;
          rdy1[i] <= s1_hit; tg1[i] <= rat_tag[iss_src1]; vl1[i] <= s1_val;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rat_vld <= '1;
      for (int j = 0; j < NREG; j++) begin
        rat_tag[j] <= '0; rat_val[j] <= '0;
      end
    end else begin
      for (int j = 0; j < NREG; j++) begin
        if (cdb_valid && !rat_vld[j] && rat_tag[j] == cdb_tag) begin
          rat_val[j] <= cdb_value;
          rat_vld[j] <= 1'b1;
        end
        if (ins && iss_dst == RW'(j)) begin
          rat_tag[j] <= free_idx;
          rat_vld[j] <= 1'b0;
        end
      end
    end
  end

  assign disp_valid = has_pick;
  assign disp_tag   = pick_idx;
  assign disp_op    = opq[pick_idx];
  assign disp_a     = vl0[pick_idx];
  assign disp_b     = vl1[pick_idx];

  assign rd_valid = rat_vld[rd_idx];
  assign rd_tag   = rat_tag[rd_idx];
  assign rd_value = rat_val[rd_idx];
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int NREG = 8,
  parameter int NRS  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic                    iss_stall,
  input logic [$clog2(NREG)-1:0] iss_dst,
  input logic                    cdb_valid,
  input logic [$clog2(NRS)-1:0]  cdb_tag,
  input logic                    disp_valid,
  input logic [$clog2(NRS)-1:0]  disp_tag,
  input logic [NRS-1:0]          busy,
  input logic [NREG-1:0]         rat_vld
);
  p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stall && iss_valid && !cdb_valid) |=> ($stable(busy) && $stable(rat_vld)));

  p_disp_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> busy[disp_tag]);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> !busy[$past(cdb_tag)]);

  p_rename_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |=> !rat_vld[$past(iss_dst)]);

  p_rat_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(rat_vld) + 1 >= $past($countones(rat_vld))));
endmodule

bind rs_sched rs_sched_chk #(.NREG(NREG), .NRS(NRS)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_stall(iss_stall),
  .iss_dst(iss_dst), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .disp_valid(disp_valid), .disp_tag(disp_tag), .busy(busy), .rat_vld(rat_vld)
);

// File: tb/rs_sched_tb_top.sv
module rs_sched_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic iss_valid = 0, cdb_valid = 0, disp_ready = 0;
  logic [3:0] iss_op = 0;
  logic [2:0] iss_dst = 0, iss_src0 = 0, iss_src1 = 0, rd_idx = 0;
  logic [1:0] cdb_tag = 0;
  logic [15:0] cdb_value = 0;
  logic iss_stall, disp_valid, rd_valid;
  logic [1:0] disp_tag, rd_tag;
  logic [3:0] disp_op;
  logic [15:0] disp_a, disp_b, rd_value;

  int checks = 0, errors = 0;
  bit done = 0;

  rs_sched dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit iv, input [3:0] op, input [2:0] d, input [2:0] a, input [2:0] b,
                      input bit cv, input [1:0] t, input [15:0] v);
    @(negedge clk);
    iss_valid = iv; iss_op = op; iss_dst = d; iss_src0 = a; iss_src1 = b;
    cdb_valid = cv; cdb_tag = t; cdb_value = v;
    @(posedge clk); #1;
    iss_valid = 0; cdb_valid = 0;
  endtask

  task automatic issue(input [3:0] op, input [2:0] d, input [2:0] a, input [2:0] b);
    step(1, op, d, a, b, 0, 0, 0);
  endtask

  task automatic bcast(input [1:0] t, input [15:0] v);
    step(0, 0, 0, 0, 0, 1, t, v);
  endtask

  task automatic take(input [1:0] t, input [3:0] op, input [15:0] a, input [15:0] b, input string req);
    @(negedge clk);
    disp_ready = 1; #1;
    chk(disp_valid && disp_tag == t, req, {disp_valid, disp_tag}, {1'b1, t});
    chk(disp_op == op && disp_a == a && disp_b == b, req, {disp_op, disp_a, disp_b}, {op, a, b});
    @(posedge clk); #1;
    disp_ready = 0;
  endtask

  task automatic rat(input [2:0] r, input bit v, input [15:0] val, input [1:0] t, input string req);
    @(negedge clk);
    rd_idx = r; #1;
    if (v) chk(rd_valid && rd_value == val, req, {rd_valid, rd_value}, {1'b1, val});
    else   chk(!rd_valid && rd_tag == t, req, {rd_valid, rd_tag}, {1'b0, t});
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(!iss_stall && !disp_valid, "R9", {iss_stall, disp_valid}, 0);
    for (int r = 0; r < 8; r++) rat(3'(r), 1, 0, 0, "R9");
  endtask

  task automatic t_basic;
    issue(4'h1, 1, 0, 0);
    rat(1, 0, 0, 0, "R7");
    take(0, 4'h1, 0, 0, "R2");
    bcast(0, 16'd5);
    rat(1, 1, 5, 0, "R6");
    issue(4'h2, 2, 1, 1);
    issue(4'h3, 3, 2, 1);
    rat(3, 0, 0, 1, "R7");
    take(0, 4'h2, 5, 5, "R5");
    @(negedge clk); #1;
    chk(!disp_valid, "R5", disp_valid, 0);
    bcast(0, 16'd10);
    take(1, 4'h3, 10, 5, "R4");
    bcast(1, 16'd15);
    rat(2, 1, 10, 0, "R6");
    rat(3, 1, 15, 0, "R8");
  endtask

  task automatic t_stale;
    issue(4'h4, 4, 1, 1);
    issue(4'h5, 4, 1, 1);
    take(0, 4'h4, 5, 5, "R5");
    take(1, 4'h5, 5, 5, "R5");
    bcast(0, 16'd7);
    rat(4, 0, 0, 1, "R6");
    bcast(1, 16'd8);
    rat(4, 1, 8, 0, "R6");
  endtask

  task automatic t_full;
    for (int k = 0; k < 4; k++) issue(4'(6 + k), 5, 1, 1);
    @(negedge clk); #1;
    chk(iss_stall, "R1", iss_stall, 1);
    issue(4'hF, 6, 1, 1);
    rat(6, 1, 0, 0, "R1");
    take(0, 4'h6, 5, 5, "R1");
    bcast(0, 16'd1);
    rat(5, 0, 0, 3, "R6");
    @(negedge clk); #1;
    chk(!iss_stall, "R8", iss_stall, 0);
    issue(4'hA, 7, 1, 1);
    rat(7, 0, 0, 0, "R8");
    take(0, 4'hA, 5, 5, "R5");
    take(1, 4'h7, 5, 5, "R5");
    take(2, 4'h8, 5, 5, "R5");
    take(3, 4'h9, 5, 5, "R5");
    bcast(0, 16'd70);
    bcast(1, 16'd2);
    bcast(2, 16'd3);
    bcast(3, 16'd33);
    rat(5, 1, 33, 0, "R6");
    rat(7, 1, 70, 0, "R6");
  endtask

  task automatic t_bypass;
    issue(4'hB, 6, 1, 1);
    take(0, 4'hB, 5, 5, "R5");
    step(1, 4'hC, 7, 6, 1, 1, 0, 16'd42);
    take(1, 4'hC, 42, 5, "R3");
    rat(6, 1, 42, 0, "R3");
    bcast(1, 16'd9);
    rat(7, 1, 9, 0, "R8");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_basic;
    t_stale;
    t_full;
    t_bypass;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule